// File: doc/BRIEF.md
# Dual-Register Programmable Output Cell

This block is one output macrocell of a small programmable logic device. It holds two storage elements. Static configuration inputs set, for each element on its own, whether it loads its data term or toggles on it, and whether it is clocked by the shared dedicated clock pin or by its own clock product term. The two elements can therefore run on unrelated clocks. Product terms are built by an array outside this block and reach the cell as plain signals.

Each element has a private asynchronous clear term. A preset line shared by the whole device acts synchronously on each element's selected clock edge. A clear always wins over a preset. A compatibility input restricts the cell to an older subset: every element is a loading element clocked by its own product term.

One element, chosen by configuration, drives the pad through a selectable inversion. An enable term gates the pad driver. Each element's state is always returned on its own feedback output. The level on the pad is returned on a separate input path, whatever the driver is doing.

Top module: `pld_out_cell`

## Requirements
- R1: While `rst_n` is low, every element holds 0, and `pad_o` equals `cfg_out_inv`.
- R2: When `cfg_tmode[i]` is 0, element i takes the value of `sum_term[i]` on each rising edge of its selected clock.
- R3: When `cfg_tmode[i]` is 1, element i inverts its state on a selected clock edge if `sum_term[i]` is 1, and keeps its state if `sum_term[i]` is 0.
- R4: `cfg_pinclk[i]` = 1 selects `clk_pin` as the clock of element i, and 0 selects `clk_term[i]`. Edges on the source that is not selected do not change the element.
- R5: The two elements update independently. An edge on one element's clock leaves the other element unchanged.
- R6: While `clr_term[i]` is high, element i is 0. The clear takes effect without any clock edge and holds through clock edges.
- R7: When `preset` is high on a selected clock edge, element i becomes 1 in either mode. A high `preset` with no edge changes nothing.
- R8: When `clr_term[i]` and `preset` are both high on a clock edge, element i stays 0.
- R9: When `cfg_compat` is 1, `cfg_tmode` and `cfg_pinclk` have no effect. Every element loads `sum_term[i]` on rising edges of `clk_term[i]` only.
- R10: `pad_o` is element `cfg_out_sel` XOR `cfg_out_inv`. A select value of 0 picks element 0 and 1 picks element 1.
- R11: `pad_oe` follows `oe_term` in the same cycle. A 0 means the pad is not driven.
- R12: `pad_fb` always equals `pad_i`, regardless of `pad_oe` and the element states.
- R13: `reg_fb[i]` always carries the true state of element i. Output selection and inversion do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin | input | 1 | Shared dedicated clock pin |
| rst_n | input | 1 | Device-level asynchronous reset, active low |
| cfg_compat | input | 1 | Older-subset mode: loading elements on product-term clocks |
| cfg_tmode | input | NUM_FF | Per element: 1 toggle, 0 load |
| cfg_pinclk | input | NUM_FF | Per element: 1 pin clock, 0 product-term clock |
| cfg_out_sel | input | SEL_W | Element that drives the pad |
| cfg_out_inv | input | 1 | Invert pad data |
| sum_term | input | NUM_FF | Per-element data sum term |
| clk_term | input | NUM_FF | Per-element clock product term |
| clr_term | input | NUM_FF | Per-element asynchronous clear term |
| preset | input | 1 | Device-wide synchronous preset |
| oe_term | input | 1 | Output-enable product term |
| pad_i | input | 1 | Level sensed on the pad |
| pad_o | output | 1 | Pad driver data |
| pad_oe | output | 1 | Pad driver enable |
| pad_fb | output | 1 | Pad input path back to the array |
| reg_fb | output | NUM_FF | Element state feedback to the array |

## Verification
On every pin clock edge the assertions check load and toggle behaviour, preset and clear for elements clocked from the pin, and the selection and polarity of pad data. Elements clocked by product terms, the immediate effect of a clear between edges, the ignored configuration in compatibility mode, and the independence of the two clocks are covered only by the bench scenarios. Those scenarios pulse product-term clocks between pin edges and compare the results against a behavioural model.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

   // Resolved operating mode of one storage element
   typedef struct packed {
      logic toggle;   // 1: invert on data, 0: load data
      logic use_pin;  // 1: dedicated clock pin, 0: own clock term
   } ff_mode_t;

endpackage

// File: rtl/pld_cell_clksel.sv
module pld_cell_clksel (
   input  logic pin_clk,
   input  logic term_clk,
   input  logic use_pin,
   output logic clk_o
);

   // Select is static configuration, so no glitch guard is needed
   assign clk_o = use_pin ? pin_clk : term_clk;

endmodule

// File: rtl/pld_cell_ff.sv
module pld_cell_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic preset,
   input  logic toggle,
   input  logic d,
   output logic q
);

   // Clear (device or private) beats preset, and preset beats data
   always_ff @(posedge clk or posedge clr or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (clr) begin
         q <= 1'b0;
      end else if (preset) begin
         q <= 1'b1;
      end else if (toggle) begin
         q <= q ^ d;
      end else begin
         q <= d;
      end
   end

endmodule

// File: rtl/pld_cell_outmux.sv
module pld_cell_outmux #(
   parameter int NUM_FF = 2,
   parameter int SEL_W  = 1
) (
   input  logic [NUM_FF-1:0] fb,
   input  logic [SEL_W-1:0]  sel,
   input  logic              inv,
   output logic              o
);

   logic pick;

   // Unused select codes fall back to element 0
   always_comb begin
      pick = fb[0];
      for (int k = 0; k < NUM_FF; k++) begin
         if (sel == SEL_W'(k)) pick = fb[k];
      end
   end

   assign o = pick ^ inv;

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
   import pld_cell_pkg::*;
#(
   parameter int NUM_FF     = 2,
   parameter bit HAS_TOGGLE = 1'b1,
   parameter bit HAS_PINCLK = 1'b1,
   localparam int SEL_W     = (NUM_FF > 1) ? $clog2(NUM_FF) : 1
) (
   input  logic              clk_pin,
   input  logic              rst_n,
   input  logic              cfg_compat,
   input  logic [NUM_FF-1:0] cfg_tmode,
   input  logic [NUM_FF-1:0] cfg_pinclk,
   input  logic [SEL_W-1:0]  cfg_out_sel,
   input  logic              cfg_out_inv,
   input  logic [NUM_FF-1:0] sum_term,
   input  logic [NUM_FF-1:0] clk_term,
   input  logic [NUM_FF-1:0] clr_term,
   input  logic              preset,
   input  logic              oe_term,
   input  logic              pad_i,
   output logic              pad_o,
   output logic              pad_oe,
   output logic              pad_fb,
   output logic [NUM_FF-1:0] reg_fb
);

   if (NUM_FF < 1 || NUM_FF > 16) begin : g_bad_count
      $error("pld_out_cell: NUM_FF must lie in 1..16");
   end

   for (genvar i = 0; i < NUM_FF; i++) begin : g_elem
      ff_mode_t mode;
      logic     elem_clk;

      // Variant: toggle capability present or absent
      if (HAS_TOGGLE) begin : g_tog
         assign mode.toggle = cfg_tmode[i] & ~cfg_compat;
      end else begin : g_no_tog
         assign mode.toggle = 1'b0;
      end

      // Variant: pin clocking present or absent
      if (HAS_PINCLK) begin : g_pin
         assign mode.use_pin = cfg_pinclk[i] & ~cfg_compat;
      end else begin : g_no_pin
         assign mode.use_pin = 1'b0;
      end

      pld_cell_clksel u_clksel (
         .pin_clk  (clk_pin),
         .term_clk (clk_term[i]),
         .use_pin  (mode.use_pin),
         .clk_o    (elem_clk)
      );

      pld_cell_ff u_ff (
         .clk    (elem_clk),
         .rst_n  (rst_n),
         .clr    (clr_term[i]),
         .preset (preset),
         .toggle (mode.toggle),
         .d      (sum_term[i]),
         .q      (reg_fb[i])
      );
   end

   pld_cell_outmux #(
      .NUM_FF (NUM_FF),
      .SEL_W  (SEL_W)
   ) u_outmux (
      .fb  (reg_fb),
      .sel (cfg_out_sel),
      .inv (cfg_out_inv),
      .o   (pad_o)
   );

   assign pad_oe = oe_term;
   assign pad_fb = pad_i;

endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
   parameter int NUM_FF     = 2,
   parameter bit HAS_TOGGLE = 1'b1,
   parameter bit HAS_PINCLK = 1'b1,
   localparam int SEL_W     = (NUM_FF > 1) ? $clog2(NUM_FF) : 1
) (
   input logic              clk_pin,
   input logic              rst_n,
   input logic              cfg_compat,
   input logic [NUM_FF-1:0] cfg_tmode,
   input logic [NUM_FF-1:0] cfg_pinclk,
   input logic [SEL_W-1:0]  cfg_out_sel,
   input logic              cfg_out_inv,
   input logic [NUM_FF-1:0] sum_term,
   input logic [NUM_FF-1:0] clr_term,
   input logic              preset,
   input logic              pad_o,
   input logic [NUM_FF-1:0] reg_fb
);

   for (genvar i = 0; i < NUM_FF; i++) begin : g_chk
      logic on_pin;
      logic tog;
      assign on_pin = HAS_PINCLK && !cfg_compat && cfg_pinclk[i];
      assign tog    = HAS_TOGGLE && !cfg_compat && cfg_tmode[i];

      // R2: pin-clocked loading element captures its sum term
      a_r2_load: assert property (@(posedge clk_pin) disable iff (!rst_n)
         (on_pin && !tog && !preset && !clr_term[i])
         |=> (clr_term[i] || reg_fb[i] == $past(sum_term[i])));

      // R3: pin-clocked toggling element flips on a 1
      a_r3_toggle: assert property (@(posedge clk_pin) disable iff (!rst_n)
         (on_pin && tog && !preset && !clr_term[i])
         |=> (clr_term[i] || reg_fb[i] == ($past(reg_fb[i]) ^ $past(sum_term[i]))));

      // R7: preset on a selected edge sets the element
      a_r7_preset: assert property (@(posedge clk_pin) disable iff (!rst_n)
         (on_pin && preset && !clr_term[i])
         |=> (clr_term[i] || reg_fb[i]));

      // R6, R8: an active clear keeps the element at 0
      a_r6_clear: assert property (@(posedge clk_pin) disable iff (!rst_n)
         clr_term[i] |-> !reg_fb[i]);
   end

   // R10: pad data is the selected element with polarity applied
   a_r10_pad_data: assert property (@(posedge clk_pin) disable iff (!rst_n)
      pad_o == (reg_fb[cfg_out_sel] ^ cfg_out_inv));

endmodule

bind pld_out_cell pld_out_cell_chk #(
   .NUM_FF     (NUM_FF),
   .HAS_TOGGLE (HAS_TOGGLE),
   .HAS_PINCLK (HAS_PINCLK)
) i_chk (.*);

// File: tb/test_pld_out_cell.sv
module test_pld_out_cell;

   localparam int N = 2;

   logic         clk_pin = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_compat = 1'b0;
   logic [N-1:0] cfg_tmode = '0;
   logic [N-1:0] cfg_pinclk = '0;
   logic [0:0]   cfg_out_sel = '0;
   logic         cfg_out_inv = 1'b0;
   logic [N-1:0] sum_term = '0;
   logic [N-1:0] clk_term = '0;
   logic [N-1:0] clr_term = '0;
   logic         preset = 1'b0;
   logic         oe_term = 1'b0;
   logic         pad_i = 1'b0;
   logic         pad_o, pad_oe, pad_fb;
   logic [N-1:0] reg_fb;

   int  total = 0;
   int  bad = 0;
   bit  mon_en = 1'b0;
   bit  done = 1'b0;

   always #5 clk_pin = ~clk_pin;

   pld_out_cell i_pld_out_cell (
      .clk_pin, .rst_n, .cfg_compat, .cfg_tmode, .cfg_pinclk,
      .cfg_out_sel, .cfg_out_inv, .sum_term, .clk_term, .clr_term,
      .preset, .oe_term, .pad_i, .pad_o, .pad_oe, .pad_fb, .reg_fb
   );

   // Behavioural reference: one integer per element
   int   m_st [N] = '{0, 0};
   logic [N-1:0] m_clk;

   for (genvar g = 0; g < N; g++) begin : g_model
      assign m_clk[g] = (!cfg_compat && cfg_pinclk[g]) ? clk_pin : clk_term[g];
      always @(posedge m_clk[g] or posedge clr_term[g] or negedge rst_n) begin
         if (!rst_n || clr_term[g])                              m_st[g] <= 0;
         else if (preset)                                        m_st[g] <= 1;
         else if (!cfg_compat && cfg_tmode[g])                   m_st[g] <= sum_term[g] ? 1 - m_st[g] : m_st[g];
         else                                                    m_st[g] <= sum_term[g] ? 1 : 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the edge
   always @(posedge clk_pin) begin
      #2;
      if (mon_en) begin
         logic [N-1:0] mv;
         for (int k = 0; k < N; k++) mv[k] = (m_st[k] != 0);
         chk("R13 model reg_fb", 32'(reg_fb), 32'(mv));
         chk("R10 model pad_o", 32'(pad_o), 32'(mv[cfg_out_sel] ^ cfg_out_inv));
         chk("R11 model pad_oe", 32'(pad_oe), 32'(oe_term));
         chk("R12 model pad_fb", 32'(pad_fb), 32'(pad_i));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk_pin);
   endtask

   // Product-term clock pulse placed between pin clock edges
   task automatic pt_pulse(input int i);
      @(negedge clk_pin);
      #2 clk_term[i] = 1'b1;
      #2 clk_term[i] = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      #1;
      chk("R1 reset reg_fb", 32'(reg_fb), 32'h0);
      chk("R1 reset pad_o", 32'(pad_o), 32'h0);
      @(negedge clk_pin);
      rst_n = 1'b1;
      mon_en = 1'b1;

      // R2, R4: element 0 on its product-term clock
      sum_term = 2'b01;
      pt_pulse(0);
      #1 chk("R2 load on term clock", 32'(reg_fb), 32'h1);
      @(negedge clk_pin);
      sum_term = 2'b00;
      tick(3);
      #1 chk("R4 pin edges ignored", 32'(reg_fb), 32'h1);

      // R4, R5: element 1 moves to the pin clock, element 0 idle
      @(negedge clk_pin);
      cfg_pinclk = 2'b10;
      sum_term = 2'b10;
      tick(2);
      #1 chk("R5 independent clocks", 32'(reg_fb), 32'h3);

      // R3: toggle on element 1
      @(negedge clk_pin);
      cfg_tmode = 2'b10;
      #7 chk("R3 toggle to 0", 32'(reg_fb[1]), 32'h0);
      #10 chk("R3 toggle to 1", 32'(reg_fb[1]), 32'h1);
      @(negedge clk_pin);
      sum_term = 2'b00;
      tick(2);
      #1 chk("R3 hold on 0", 32'(reg_fb), 32'h3);

      // R6: immediate clear of element 0
      @(negedge clk_pin);
      sum_term = 2'b01;
      #1 clr_term[0] = 1'b1;
      #1 chk("R6 clear without clock", 32'(reg_fb[0]), 32'h0);
      pt_pulse(0);
      #1 chk("R6 clear holds over edge", 32'(reg_fb[0]), 32'h0);

      // R8: clear beats preset
      @(negedge clk_pin);
      preset = 1'b1;
      pt_pulse(0);
      #1 chk("R8 clear over preset", 32'(reg_fb[0]), 32'h0);

      // R7: preset acts only on an edge
      @(negedge clk_pin);
      clr_term[0] = 1'b0;
      sum_term = 2'b00;
      #2 chk("R7 no edge no preset", 32'(reg_fb[0]), 32'h0);
      pt_pulse(0);
      #1 chk("R7 preset on edge", 32'(reg_fb[0]), 32'h1);
      @(negedge clk_pin);
      preset = 1'b0;

      // R9: compatibility mode ignores toggle and pin clock
      @(negedge clk_pin);
      cfg_compat = 1'b1;
      cfg_tmode = 2'b11;
      cfg_pinclk = 2'b11;
      sum_term = 2'b11;
      tick(2);
      #1 chk("R9 pin edges ignored", 32'(reg_fb), 32'h3);
      @(negedge clk_pin);
      sum_term = 2'b00;
      pt_pulse(1);
      #1 chk("R9 load on term clock", 32'(reg_fb), 32'h1);
      @(negedge clk_pin);
      sum_term = 2'b11;
      pt_pulse(0);
      #1 chk("R9 no toggle", 32'(reg_fb), 32'h1);
      @(negedge clk_pin);
      cfg_compat = 1'b0;
      cfg_tmode = 2'b00;
      cfg_pinclk = 2'b00;

      // R10, R13: pad data selection and polarity
      @(negedge clk_pin);
      cfg_out_sel = 1'b0; cfg_out_inv = 1'b0;
      #1 chk("R10 sel0 true", 32'(pad_o), 32'h1);
      cfg_out_inv = 1'b1;
      #1 chk("R10 sel0 inverted", 32'(pad_o), 32'h0);
      cfg_out_sel = 1'b1; cfg_out_inv = 1'b0;
      #1 chk("R10 sel1 true", 32'(pad_o), 32'h0);
      cfg_out_inv = 1'b1;
      #1 chk("R10 sel1 inverted", 32'(pad_o), 32'h1);
      chk("R13 feedback untouched", 32'(reg_fb), 32'h1);

      // R11, R12: enable and pad input path
      oe_term = 1'b1;
      #1 chk("R11 enable on", 32'(pad_oe), 32'h1);
      oe_term = 1'b0;
      #1 chk("R11 enable off", 32'(pad_oe), 32'h0);
      pad_i = 1'b1;
      #1 chk("R12 pad level with driver off", 32'(pad_fb), 32'h1);
      oe_term = 1'b1;
      pad_i = 1'b0;
      #1 chk("R12 pad level with driver on", 32'(pad_fb), 32'h0);
      tick(2);

      // R1: device reset mid-run
      @(negedge clk_pin);
      rst_n = 1'b0;
      #1 chk("R1 reset clears all", 32'(reg_fb), 32'h0);
      chk("R1 reset pad_o is polarity", 32'(pad_o), 32'(cfg_out_inv));
      tick(2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule